// File: doc/BRIEF.md
# UART Transmit Holding FIFO with Empty Interrupt

This block is the transmit half of a classic byte-wide UART register interface. Software pushes characters into a 16-entry first-in first-out store by writing the transmit holding register. The block hands those characters, oldest first, to a downstream serializer over a valid/ready stream. A status bit tells software when the store has drained completely. A transmitter-empty interrupt, reported through an identification register, tells software that it may write a whole burst again.

The stream follows the usual back-pressure rules. `tx_valid` is high whenever at least one character is held. `tx_data` shows the oldest character and holds still until the serializer takes it. A character leaves on a clock edge where `tx_valid` and `tx_ready` are both high. The serializer may hold `tx_ready` low for as long as it likes, and no character is lost while it does. Software learns nothing about fullness from the block. Once the empty indication appears, up to 16 characters fit. Any write beyond that point is discarded and raises a sticky debug flag.

The interrupt fires once for each transition of the store from non-empty to empty. It is withdrawn by any holding-register write or by a read of the identification register. It does not come back until the store refills and drains again.

Top module: `uart_tx_fifo_regs`

## Requirements
- R1: After reset, `tx_valid` and `irq` are 0, `dbg_overflow` is 0, the identification register (offset 2) reads 0x01 and the line status register (offset 5) reads 0x20.
- R2: A bus write to offset 0 while fewer than 16 characters are held appends `bus_wdata` to the store.
- R3: A bus write to offset 0 while 16 characters are held is dropped and leaves the stored characters unchanged. From the following cycle, `dbg_overflow` reads 1 and stays 1 until reset.
- R4: `tx_valid` is 1 exactly when the store is non-empty, and `tx_data` is the oldest held character. A character is removed on an edge with `tx_valid` and `tx_ready` both 1. Characters leave in write order, and `tx_data` is stable while `tx_ready` is 0.
- R5: A read at offset 5 returns bit 5 = 1 exactly when the store is empty; every other bit reads 0.
- R6: When the character count goes from non-zero to zero on an edge, `irq` is 1 from the following cycle.
- R7: A read at offset 2 returns 0x02 while the interrupt is pending and 0x01 otherwise (bit 0 is low only while pending).
- R8: A bus write to offset 0, accepted or dropped, or a read strobe at offset 2 clears a pending interrupt on that edge. If the count reaches zero on the same edge as the clear, the interrupt is set.
- R9: While the store stays empty, the interrupt does not return after it is cleared.
- R10: Reads at offsets other than 2 and 5 return 0x00, and writes to offsets other than 0 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect at offset 2) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tx_valid | output | 1 | A character is offered to the serializer |
| tx_data | output | 8 | Oldest held character |
| tx_ready | input | 1 | Serializer accepts the offered character |
| irq | output | 1 | Transmitter-empty interrupt pending |
| dbg_overflow | output | 1 | Sticky flag: a write was dropped on a full store |

## Verification
`bus_rdata` depends combinationally on `bus_addr` and the current state. The bench therefore samples it 1 ns after driving the address in the low phase of the clock, before the edge that acts on the access. A write or a pop changes `tx_valid`, `tx_data`, the status bit and `dbg_overflow` one edge later. Interrupt set and clear likewise appear one cycle after the edge on which the count reaches zero or the clearing access occurs. A bench model advances its queue, interrupt and overflow state once per cycle with the same inputs it drives. It compares those values at the next falling edge, so each expected value is due exactly one register stage after its cause.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic [2:0] OFS_THR = 3'd0;
  localparam logic [2:0] OFS_IIR = 3'd2;
  localparam logic [2:0] OFS_LSR = 3'd5;
  localparam logic [7:0] IIR_IDLE = 8'h01;
  localparam logic [7:0] IIR_TXEMPTY = 8'h02;
  localparam int LSR_EMPTY_BIT = 5;
endpackage

// File: rtl/tx_char_fifo.sv
module tx_char_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic          dropped,
  output logic          drained
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nxt;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_MAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dropped = push && full;
  assign head    = store[rd_ptr];

  always_comb begin
    count_nxt = count;
    if (do_push && !do_pop) count_nxt = count + 1'b1;
    else if (!do_push && do_pop) count_nxt = count - 1'b1;
  end

  assign drained = !empty && (count_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);

  // R3
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(head));
endmodule

// File: rtl/txe_irq_ctrl.sv
module txe_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (set_evt) pending <= 1'b1;
    else if (clr_evt) pending <= 1'b0;
  end

  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !pending);

  // R9
  rise_needs_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(set_evt));
endmodule

// File: rtl/uart_tx_fifo_regs.sv
module uart_tx_fifo_regs #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_ready,
  output logic              irq,
  output logic              dbg_overflow
);
  import uart_tx_pkg::*;

  logic thr_wr, iir_rd, empty, full, dropped, drained, pop;

  assign thr_wr = bus_wr && (bus_addr == ADDR_W'(OFS_THR));
  assign iir_rd = bus_rd && (bus_addr == ADDR_W'(OFS_IIR));
  assign pop    = tx_valid && tx_ready;

  tx_char_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(thr_wr), .push_data(bus_wdata), .pop(pop),
    .head(tx_data), .empty(empty), .full(full),
    .dropped(dropped), .drained(drained)
  );

  assign tx_valid = !empty;

  txe_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_evt(drained), .clr_evt(thr_wr || iir_rd),
    .pending(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dbg_overflow <= 1'b0;
    else if (dropped) dbg_overflow <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_IIR))
      bus_rdata = irq ? DW'(IIR_TXEMPTY) : DW'(IIR_IDLE);
    else if (bus_addr == ADDR_W'(OFS_LSR))
      bus_rdata[LSR_EMPTY_BIT] = empty;
  end

  // R3
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_overflow |=> dbg_overflow);

  // R6
  drain_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && $past(!tx_valid || tx_ready) && !thr_wr && full == 1'b0 && drained) |=> irq);

  // R9
  irq_only_when_empty_or_refilled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !irq && !tx_ready) |=> (!irq));
endmodule

// File: tb/uart_tx_fifo_regs_tb.sv
module uart_tx_fifo_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, tx_ready = 1'b0;
  logic [2:0] bus_addr = 3'd1;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, tx_data;
  logic tx_valid, irq, dbg_overflow;

  int n_chk = 0, n_fail = 0;
  logic [7:0] q[$];
  logic m_irq = 1'b0, m_ovf = 1'b0;

  always #4 clk = ~clk;

  uart_tx_fifo_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .irq(irq), .dbg_overflow(dbg_overflow)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a, input int cnt, input logic ip);
    if (a == 3'd2) return ip ? 8'h02 : 8'h01;
    if (a == 3'd5) return (cnt == 0) ? 8'h20 : 8'h00;
    return 8'h00;
  endfunction

  // One cycle: drive at negedge, check combinational read and state, then advance model.
  task automatic cycle(input logic wr, input logic rd, input logic [2:0] a,
                       input logic [7:0] d, input logic rdy);
    logic push, pop, thr, iirr;
    int cnt;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tx_ready = rdy;
    #1;
    cnt = q.size();
    check("R4 tx_valid", {7'd0, tx_valid}, {7'd0, cnt != 0});
    if (cnt != 0) check("R4 tx_data order", tx_data, q[0]);
    check("R6/R8/R9 irq", {7'd0, irq}, {7'd0, m_irq});
    check("R3 overflow", {7'd0, dbg_overflow}, {7'd0, m_ovf});
    if (a == 3'd2) check("R7 iir read", bus_rdata, exp_read(a, cnt, m_irq));
    else if (a == 3'd5) check("R5 lsr read", bus_rdata, exp_read(a, cnt, m_irq));
    else check("R10 other read", bus_rdata, exp_read(a, cnt, m_irq));
    thr = wr && (a == 3'd0);
    iirr = rd && (a == 3'd2);
    pop = (cnt != 0) && rdy;
    push = thr && (cnt < 16);
    if (thr && cnt == 16) m_ovf = 1'b1;
    if (pop) void'(q.pop_front());
    if (push) q.push_back(d);
    if (cnt != 0 && q.size() == 0) m_irq = 1'b1;
    else if (thr || iirr) m_irq = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 overflow", {7'd0, dbg_overflow}, 8'd0);
    bus_addr = 3'd2; #1; check("R1 iir", bus_rdata, 8'h01);
    bus_addr = 3'd5; #1; check("R1 lsr", bus_rdata, 8'h20);
    rst_n = 1'b1;

    // R2 R3 fill to 16 with serializer stalled, then an extra write is dropped
    for (int i = 0; i < 17; i++) cycle(1'b1, 1'b0, 3'd0, 8'hA0 + 8'(i), 1'b0);
    // R10 writes elsewhere are ignored
    cycle(1'b1, 1'b0, 3'd3, 8'h55, 1'b0);
    cycle(1'b0, 1'b0, 3'd5, 8'h00, 1'b0);
    check("R3 overflow set", {7'd0, dbg_overflow}, 8'd1);
    // R4 R6 drain in order; interrupt raised after last pop
    for (int i = 0; i < 18; i++) cycle(1'b0, 1'b0, 3'd5, 8'h00, 1'b1);
    check("R6 irq after drain", {7'd0, irq}, 8'd1);
    // R8 R9 IIR read clears, stays clear while empty
    cycle(1'b0, 1'b1, 3'd2, 8'h00, 1'b1);
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 3'd2, 8'h00, 1'b1);
    check("R9 no rearm", {7'd0, irq}, 8'd0);
    // R8 emptying coincides with IIR read: set wins
    cycle(1'b1, 1'b0, 3'd0, 8'h3C, 1'b0);
    cycle(1'b0, 1'b1, 3'd2, 8'h00, 1'b1);
    cycle(1'b0, 1'b0, 3'd2, 8'h00, 1'b0);
    check("R8 set wins", {7'd0, irq}, 8'd1);
    // R8 THR write clears
    cycle(1'b1, 1'b0, 3'd0, 8'h77, 1'b0);
    cycle(1'b0, 1'b0, 3'd2, 8'h00, 1'b1);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic w, r;
      a = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) a = 3'd0;
      w = ($urandom_range(0, 2) == 0);
      r = ($urandom_range(0, 1) == 0);
      cycle(w, r, a, 8'($urandom), ($urandom_range(0, 2) != 0));
    end
    cycle(1'b0, 1'b0, 3'd1, 8'h00, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule